// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

An 8-bit serial port that either drives the SPI bus as master or answers on it as slave. A single shift register does both sending and receiving. A receive buffer catches each finished byte. A small control word and a timing word set the port's behaviour: enable, clock idle level, edge selection, master sample position and the role/rate code. The same two words report the collision, overrun and buffer-full flags. Each completed byte raises an interrupt flag.

A low-power hold input stops the master. While it is high, the generated clock freezes at its current level, and the transfer continues from the same bit once the hold drops. A slave is clocked only by the incoming bus clock, so it keeps shifting while held. When its byte completes and the interrupt is enabled, it raises a wake request.

Top module: `spi_dual_port`

## Requirements
- R1: With idle level `cpol` = ctrl bit 4 and edge bit `cke` = timing bit 0, the bus clock rests at `cpol` when no transfer runs. During a master bit it is active (not `cpol`) in the second half of the bit when `cke`=1 (SPI modes 0/2) and in the first half when `cke`=0 (modes 1/3).
- R2: The master sample position `smp` (timing bit 1) takes the incoming bit at the middle of the bit time when 0 and at its end when 1.
- R3: The role code in ctrl bits 3:0 selects the master at a system clock divided by 4 (0000), 16 (0001) or 64 (0010), a slave using its select line (0100), or a slave ignoring its select line (0101). In master mode each bit holds the bus clock active for exactly half its divider.
- R4: Data goes out and comes in MSB first. A completed byte is placed in the buffer, sets buffer-full (status bit 0) and sets the interrupt flag.
- R5: In master mode, holding stops the bus clock and the bit timing. After release the byte completes with the same data as without the hold.
- R6: In slave mode, bytes are received while held. A completed byte with the interrupt enabled drives the wake request.
- R7: A buffer write during a transfer sets write-collision (ctrl bit 7) and leaves the byte being shifted unchanged.
- R8: A byte that completes while buffer-full is set sets overrun (ctrl bit 6) and leaves the buffer holding the older byte.
- R9: In slave-with-select mode, raising the active-low select mid-byte clears the bit count, and clock edges while it is high are ignored. In slave-ignore-select mode, bytes are received with the select high.
- R10: Reset clears ctrl, timing, buffer-full, buffer and interrupt flag and aborts a transfer. Clearing enable aborts a master transfer, and the bus clock returns to idle.
- R11: A buffer read clears buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Low-power hold request |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word {wcol, ovf, en, cpol, role[3:0]} |
| stat_we | input | 1 | Write strobe for the timing bits |
| stat_wdata | input | 2 | Timing bits {smp, cke} |
| buf_we | input | 1 | Write a byte to transmit |
| buf_wdata | input | W | Byte to transmit |
| buf_re | input | 1 | Buffer read strobe, clears buffer-full |
| irq_en | input | 1 | Interrupt enable for the wake request |
| irq_clr | input | 1 | Clears the interrupt flag |
| ctrl_q | output | 8 | Control word read-back |
| stat_q | output | 8 | {smp, cke, 5'b0, full} |
| buf_q | output | W | Received byte buffer |
| irq_flag | output | 1 | Byte-complete interrupt flag |
| wake_o | output | 1 | Wake request |
| sck_o | output | 1 | Bus clock driven as master |
| sck_i | input | 1 | Bus clock received as slave |
| ss_n_i | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the port with its defaults: an 8-bit word and dividers of 4, 16 and 64. At these values every rate finishes a byte within a few hundred cycles, so the active-clock time of each rate can be counted edge by edge. Both roles are run in all four clock modes. Holds are placed at random points inside master bytes. A mid-bit change of the incoming data separates the two sample positions.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

    typedef enum logic [3:0] {
        PM_FAST     = 4'b0000,
        PM_MID      = 4'b0001,
        PM_SLOW     = 4'b0010,
        PM_SLV_SEL  = 4'b0100,
        PM_SLV_FREE = 4'b0101
    } port_mode_e;

    typedef struct packed {
        logic       wcol;
        logic       ovf;
        logic       en;
        logic       cpol;
        port_mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic smp;
        logic cke;
    } timing_t;

    function automatic logic is_master(input port_mode_e m);
        return (m == PM_FAST) || (m == PM_MID) || (m == PM_SLOW);
    endfunction

    function automatic logic is_slave(input port_mode_e m);
        return (m == PM_SLV_SEL) || (m == PM_SLV_FREE);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/spi_master_seq.sv
module spi_master_seq #(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          start,
    input  logic          freeze,
    input  logic [CW-1:0] half_len,
    output logic          busy,
    output logic          second_half,
    output logic          mid_tick,
    output logic          end_tick,
    output logic          last_tick
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic          step;
    logic          wrap;

    assign step      = busy && run && !freeze;
    assign wrap      = step && (cnt == half_len - CW'(1));
    assign mid_tick  = wrap && !second_half;
    assign end_tick  = wrap && second_half;
    assign last_tick = end_tick && (bidx == BW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy        <= 1'b0;
            cnt         <= '0;
            second_half <= 1'b0;
            bidx        <= '0;
        end else if (start && !busy) begin
            busy        <= 1'b1;
            cnt         <= '0;
            second_half <= 1'b0;
            bidx        <= '0;
        end else if (step) begin
            if (wrap) begin
                cnt         <= '0;
                second_half <= !second_half;
                if (second_half) begin
                    bidx <= bidx + BW'(1);
                    if (last_tick) busy <= 1'b0;
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/spi_slave_edge.sv
module spi_slave_edge #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic use_ss,
    input  logic ss_n,
    input  logic sck,
    input  logic cpol,
    input  logic cke,
    output logic sample_tick,
    output logic last_tick,
    output logic mid_byte
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic          sck_q;
    logic [BW-1:0] cnt;
    logic          selected;
    logic          lead;
    logic          trail;

    assign selected    = !use_ss || !ss_n;
    assign lead        = (sck_q == cpol) && (sck != cpol);
    assign trail       = (sck_q != cpol) && (sck == cpol);
    assign sample_tick = run && selected && (cke ? lead : trail);
    assign last_tick   = sample_tick && (cnt == BW'(W - 1));
    assign mid_byte    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cnt   <= '0;
        end else begin
            sck_q <= sck;
            if (!run || !selected) begin
                cnt <= '0;
            end else if (sample_tick) begin
                cnt <= last_tick ? '0 : cnt + BW'(1);
            end
        end
    end
endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
    import spi_dual_pkg::*;
#(
    parameter int W        = 8,
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_i,
    input  logic         ctrl_we,
    input  logic [7:0]   ctrl_wdata,
    input  logic         stat_we,
    input  logic [1:0]   stat_wdata,
    input  logic         buf_we,
    input  logic [W-1:0] buf_wdata,
    input  logic         buf_re,
    input  logic         irq_en,
    input  logic         irq_clr,
    output logic [7:0]   ctrl_q,
    output logic [7:0]   stat_q,
    output logic [W-1:0] buf_q,
    output logic         irq_flag,
    output logic         wake_o,
    output logic         sck_o,
    input  logic         sck_i,
    input  logic         ss_n_i,
    input  logic         sdi,
    output logic         sdo
);
    localparam int DIV_MAX = max3(DIV_FAST, DIV_MID, DIV_SLOW);
    localparam int CW      = $clog2(DIV_MAX / 2 + 1);

    ctrl_t          ctrl;
    timing_t        tim;
    logic [W-1:0]   shreg;
    logic [W-1:0]   rbuf;
    logic           full;
    logic           irq;
    logic           samp;

    logic           master_on;
    logic           slave_on;
    logic [CW-1:0]  half_len;
    logic           m_busy, m_second, m_mid, m_end, m_last;
    logic           s_sample, s_last, s_mid;
    logic           busy_any;
    logic           collide;
    logic           load;
    logic           done;
    logic           m_bit;
    logic [W-1:0]   next_byte;

    assign master_on = ctrl.en && is_master(ctrl.mode);
    assign slave_on  = ctrl.en && is_slave(ctrl.mode);

    always_comb begin
        case (ctrl.mode)
            PM_MID:  half_len = CW'(DIV_MID / 2);
            PM_SLOW: half_len = CW'(DIV_SLOW / 2);
            default: half_len = CW'(DIV_FAST / 2);
        endcase
    end

    assign busy_any  = m_busy || s_mid;
    assign collide   = buf_we && busy_any;
    assign load      = buf_we && !busy_any;
    assign done      = m_last || s_last;
    assign m_bit     = tim.smp ? sdi : samp;
    assign next_byte = {shreg[W-2:0], (m_end ? m_bit : sdi)};

    spi_master_seq #(.W(W), .CW(CW)) u_mseq (
        .clk         (clk),
        .rst         (rst),
        .run         (master_on),
        .start       (load && master_on),
        .freeze      (hold_i),
        .half_len    (half_len),
        .busy        (m_busy),
        .second_half (m_second),
        .mid_tick    (m_mid),
        .end_tick    (m_end),
        .last_tick   (m_last)
    );

    spi_slave_edge #(.W(W)) u_sedge (
        .clk         (clk),
        .rst         (rst),
        .run         (slave_on),
        .use_ss      (ctrl.mode == PM_SLV_SEL),
        .ss_n        (ss_n_i),
        .sck         (sck_i),
        .cpol        (ctrl.cpol),
        .cke         (tim.cke),
        .sample_tick (s_sample),
        .last_tick   (s_last),
        .mid_byte    (s_mid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            tim   <= '0;
            shreg <= '0;
            rbuf  <= '0;
            full  <= 1'b0;
            irq   <= 1'b0;
            samp  <= 1'b0;
        end else begin
            if (ctrl_we) ctrl <= ctrl_t'(ctrl_wdata);
            if (collide) ctrl.wcol <= 1'b1;
            if (done && full) ctrl.ovf <= 1'b1;

            if (stat_we) tim <= timing_t'(stat_wdata);

            if (m_mid && !tim.smp) samp <= sdi;

            if (load) shreg <= buf_wdata;
            else if (m_end || s_sample) shreg <= next_byte;

            if (buf_re) full <= 1'b0;
            if (done && !full) begin
                rbuf <= next_byte;
                full <= 1'b1;
            end

            if (irq_clr) irq <= 1'b0;
            if (done) irq <= 1'b1;
        end
    end

    assign sck_o    = ctrl.cpol ^ (master_on && m_busy && (tim.cke ? m_second : !m_second));
    assign sdo      = shreg[W-1];
    assign ctrl_q   = ctrl;
    assign stat_q   = {tim.smp, tim.cke, 5'b0, full};
    assign buf_q    = rbuf;
    assign irq_flag = irq;
    assign wake_o   = irq && irq_en;
endmodule

// File: rtl/spi_dual_port_chk.sv
module spi_dual_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         hold_i,
    input logic         ctrl_we,
    input logic         stat_we,
    input logic         buf_we,
    input logic         buf_re,
    input logic         irq_en,
    input logic [7:0]   ctrl_q,
    input logic [7:0]   stat_q,
    input logic [W-1:0] buf_q,
    input logic         irq_flag,
    input logic         wake_o,
    input logic         sck_o,
    input logic         done,
    input logic         busy_any,
    input logic         master_on
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy_any |-> (sck_o == ctrl_q[4]));                                  // R1
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold_i && master_on && !ctrl_we && !stat_we && !buf_we) |=> $stable(sck_o)); // R5
    AST_WAKE_REQ: assert property (@(posedge clk) disable iff (rst)
        (done && irq_en) |=> (wake_o || !irq_en));                            // R6
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        (buf_we && busy_any) |=> ctrl_q[7]);                                  // R7
    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (done && stat_q[0]) |=> (ctrl_q[6] && $stable(buf_q)));               // R8
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == 8'h00 && stat_q == 8'h00 && !irq_flag));    // R10
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (buf_re && !done) |=> !stat_q[0]);                                    // R11
endmodule

bind spi_dual_port spi_dual_port_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (hold_i),
    .ctrl_we   (ctrl_we),
    .stat_we   (stat_we),
    .buf_we    (buf_we),
    .buf_re    (buf_re),
    .irq_en    (irq_en),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .buf_q     (buf_q),
    .irq_flag  (irq_flag),
    .wake_o    (wake_o),
    .sck_o     (sck_o),
    .done      (done),
    .busy_any  (busy_any),
    .master_on (master_on)
);

// File: tb/test_spi_dual_port.sv
`timescale 1ns/1ps
module test_spi_dual_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold_i = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       stat_we = 1'b0;
    logic [1:0] stat_wdata = '0;
    logic       buf_we = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       buf_re = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] ctrl_q, stat_q, buf_q;
    logic       irq_flag, wake_o, sck_o, sdo;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    spi_dual_port i_spi_dual_port (
        .clk(clk), .rst(rst), .hold_i(hold_i),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re),
        .irq_en(irq_en), .irq_clr(irq_clr),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .buf_q(buf_q),
        .irq_flag(irq_flag), .wake_o(wake_o),
        .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi(sdi), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [3:0] m);
        return (m == 4'b0001) ? 16 : (m == 4'b0010) ? 64 : 4;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input bit en, input bit cpol, input logic [3:0] m);
        ctrl_we = 1'b1; ctrl_wdata = {2'b00, en, cpol, m};
        tick(1); ctrl_we = 1'b0;
    endtask

    task automatic wr_stat(input bit smp, input bit cke);
        stat_we = 1'b1; stat_wdata = {smp, cke};
        tick(1); stat_we = 1'b0;
    endtask

    task automatic pulse_read();
        buf_re = 1'b1; tick(1); buf_re = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    task automatic write_buf(input logic [7:0] v);
        buf_we = 1'b1; buf_wdata = v; tick(1); buf_we = 1'b0;
    endtask

    // Master transfer with the bench acting as the remote slave.
    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] pa, input logic [7:0] pb,
                          input bit cpol, input bit cke, input bit smp, input logic [3:0] m,
                          input int hold_at, input int hold_len, input int wcol_at, input bit split,
                          output logic [7:0] got, output int act, output bit idle_lvl,
                          output bit first_lvl, output bit hold_ok);
        int  cyc;
        int  bidx;
        bit  prev, cur, lead, hsck;
        wr_ctrl(0, cpol, m);
        wr_stat(smp, cke);
        wr_ctrl(1, cpol, m);
        pulse_read();
        pulse_irq_clr();
        idle_lvl = sck_o;
        bidx = cke ? 0 : -1;
        sdi = cke ? pa[7] : 1'b0;
        prev = cpol; got = '0; act = 0; hold_ok = 1'b1; hsck = 1'b0; cyc = 0;
        write_buf(tx);
        first_lvl = sck_o;
        while (!irq_flag && cyc < 4000) begin
            cur = sck_o;
            if (cur != prev) begin
                lead = (prev == cpol);
                if (cke ? !lead : lead) begin
                    bidx++;
                    sdi = (bidx >= 0 && bidx < 8) ? pa[7 - bidx] : 1'b0;
                end
                if (split && cke && lead && bidx >= 0 && bidx < 8) sdi = pb[7 - bidx];
                if (cke ? lead : !lead) got = {got[6:0], sdo};
            end
            if (cur != cpol) act++;
            prev = cur;
            if (hold_len > 0 && cyc > hold_at && cyc <= hold_at + hold_len && cur != hsck) hold_ok = 1'b0;
            if (hold_len > 0 && cyc == hold_at) begin hold_i = 1'b1; hsck = cur; end
            if (hold_len > 0 && cyc == hold_at + hold_len) hold_i = 1'b0;
            if (cyc == wcol_at) begin buf_we = 1'b1; buf_wdata = ~tx; end
            if (cyc == wcol_at + 1) buf_we = 1'b0;
            tick(1);
            cyc++;
        end
        hold_i = 1'b0;
        buf_we = 1'b0;
    endtask

    // One slave bit with the bench acting as bus master.
    task automatic s_bit(input bit d, input bit cpol, input bit cke, inout logic [7:0] got);
        if (cke) begin
            sdi = d; got = {got[6:0], sdo};
            sck_i = ~cpol; tick(3);
            sck_i = cpol;  tick(3);
        end else begin
            sck_i = ~cpol; tick(3);
            sdi = d; got = {got[6:0], sdo};
            sck_i = cpol;  tick(3);
        end
    endtask

    task automatic s_setup(input bit cpol, input bit cke, input logic [3:0] m, input bit keep_full);
        wr_ctrl(0, cpol, m);
        sck_i = cpol;
        tick(1);
        wr_stat(1'b0, cke);
        wr_ctrl(1, cpol, m);
        if (!keep_full) pulse_read();
        pulse_irq_clr();
    endtask

    task automatic s_xfer(input logic [7:0] tx, input logic [7:0] pat, input bit cpol, input bit cke,
                          input logic [3:0] m, input bit ssn, input bit hold, input bit keep_full,
                          output logic [7:0] got);
        s_setup(cpol, cke, m, keep_full);
        ss_n_i = ssn;
        write_buf(tx);
        hold_i = hold;
        tick(2);
        got = '0;
        for (int k = 0; k < 8; k++) s_bit(pat[7 - k], cpol, cke, got);
        tick(2);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] got, tx, pa, pb;
        int         act;
        bit         idle_lvl, first_lvl, hold_ok;
        bit         cpol, cke, smp;
        logic [3:0] m;
        void'($urandom(32'h5EED_0042));

        tick(4);
        rst = 1'b0;
        tick(1);
        // R10: reset state
        chk(ctrl_q == 8'h00 && stat_q == 8'h00, "R10 reset regs", {ctrl_q, stat_q}, 0);
        chk(buf_q == 8'h00 && !irq_flag && !wake_o && !sck_o, "R10 reset outputs",
            {buf_q, irq_flag, wake_o, sck_o}, 0);

        // Directed master: all four clock modes and all three rates
        for (int i = 0; i < 4; i++) begin
            cpol = i[1]; cke = !i[0];
            m = 4'(i % 3);
            tx = 8'hA5 ^ 8'(i * 37); pa = 8'h3C ^ 8'(i * 91);
            m_xfer(tx, pa, 8'h00, cpol, cke, i[0], m, -1, 0, -1, 1'b0, got, act, idle_lvl, first_lvl, hold_ok);
            chk(idle_lvl == cpol, "R1 idle level", idle_lvl, cpol);
            chk(first_lvl == (cke ? cpol : !cpol), "R1 first half level", first_lvl, cke ? cpol : !cpol);
            chk(got == tx, "R4 master tx MSB first", got, tx);
            chk(buf_q == pa, "R4 master rx byte", buf_q, pa);
            chk(stat_q[0] && irq_flag, "R4 full and irq", {stat_q[0], irq_flag}, 2'b11);
            chk(act == 4 * div_of(m), "R3 active clock time", act, 4 * div_of(m));
        end

        // R2: data changes at mid-bit; sample position picks one half
        m_xfer(8'h0F, 8'hC3, 8'h5A, 1'b0, 1'b1, 1'b0, 4'b0001, -1, 0, -1, 1'b1, got, act, idle_lvl, first_lvl, hold_ok);
        chk(buf_q == 8'hC3, "R2 mid-bit sampling", buf_q, 8'hC3);
        m_xfer(8'h0F, 8'hC3, 8'h5A, 1'b0, 1'b1, 1'b1, 4'b0001, -1, 0, -1, 1'b1, got, act, idle_lvl, first_lvl, hold_ok);
        chk(buf_q == 8'h5A, "R2 end-of-bit sampling", buf_q, 8'h5A);

        // R5: directed master hold
        m_xfer(8'h96, 8'h71, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0001, 20, 37, -1, 1'b0, got, act, idle_lvl, first_lvl, hold_ok);
        chk(hold_ok, "R5 clock frozen during hold", hold_ok, 1);
        chk(got == 8'h96 && buf_q == 8'h71, "R5 byte after hold", {got, buf_q}, 16'h9671);

        // R7: write collision
        m_xfer(8'hE1, 8'h2B, 8'h00, 1'b0, 1'b1, 1'b0, 4'b0010, -1, 0, 30, 1'b0, got, act, idle_lvl, first_lvl, hold_ok);
        chk(ctrl_q[7], "R7 write collision flag", ctrl_q[7], 1);
        chk(got == 8'hE1, "R7 shifted byte unchanged", got, 8'hE1);

        // Random master transfers
        for (int i = 0; i < 8; i++) begin
            cpol = 1'($urandom_range(0, 1)); cke = 1'($urandom_range(0, 1)); smp = 1'($urandom_range(0, 1));
            m = 4'($urandom_range(0, 2));
            tx = 8'($urandom); pa = 8'($urandom);
            m_xfer(tx, pa, 8'h00, cpol, cke, smp, m, (i % 2) ? int'($urandom_range(2, 40)) : -1,
                   (i % 2) ? int'($urandom_range(1, 20)) : 0, -1, 1'b0, got, act, idle_lvl, first_lvl, hold_ok);
            chk(got == tx && buf_q == pa, "R4 random master byte", {got, buf_q}, {tx, pa});
            chk(hold_ok, "R5 random hold freeze", hold_ok, 1);
        end

        // Random slave transfers
        for (int i = 0; i < 8; i++) begin
            cpol = 1'($urandom_range(0, 1)); cke = 1'($urandom_range(0, 1));
            tx = 8'($urandom); pa = 8'($urandom);
            s_xfer(tx, pa, cpol, cke, (i % 2) ? 4'b0101 : 4'b0100, 1'b0, 1'b0, 1'b0, got);
            chk(got == tx && buf_q == pa, "R4 random slave byte", {got, buf_q}, {tx, pa});
            chk(irq_flag && stat_q[0], "R4 slave irq and full", {irq_flag, stat_q[0]}, 2'b11);
        end

        // R6: slave keeps shifting under hold, wake request
        irq_en = 1'b1;
        s_xfer(8'h5C, 8'hB7, 1'b1, 1'b1, 4'b0100, 1'b0, 1'b1, 1'b0, got);
        chk(buf_q == 8'hB7 && got == 8'h5C, "R6 slave byte while held", {got, buf_q}, 16'h5CB7);
        chk(wake_o, "R6 wake request", wake_o, 1);
        hold_i = 1'b0; irq_en = 1'b0;
        tick(1);
        chk(!wake_o, "R6 wake gated by enable", wake_o, 0);

        // R11: read clears full
        pulse_read();
        chk(!stat_q[0], "R11 read clears full", stat_q[0], 0);

        // R8: overrun keeps older byte
        s_xfer(8'h11, 8'h4E, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b0, got);
        chk(buf_q == 8'h4E, "R9 ignore-select slave with select high", buf_q, 8'h4E);
        s_xfer(8'h22, 8'hD9, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b1, got);
        chk(ctrl_q[6], "R8 overrun flag", ctrl_q[6], 1);
        chk(buf_q == 8'h4E, "R8 buffer keeps older byte", buf_q, 8'h4E);

        // R9: select raised mid-byte restarts the count; edges ignored while high
        s_setup(1'b0, 1'b1, 4'b0100, 1'b0);
        ss_n_i = 1'b0;
        write_buf(8'h00);
        got = '0;
        for (int k = 0; k < 3; k++) s_bit(1'b1, 1'b0, 1'b1, got);
        ss_n_i = 1'b1; tick(3);
        for (int k = 0; k < 8; k++) s_bit(1'b1, 1'b0, 1'b1, got);
        chk(!irq_flag && !stat_q[0], "R9 no byte while deselected", {irq_flag, stat_q[0]}, 0);
        ss_n_i = 1'b0; tick(2);
        for (int k = 0; k < 8; k++) s_bit(k[0], 1'b0, 1'b1, got);
        tick(2);
        chk(buf_q == 8'h55 && irq_flag, "R9 count restarted", {buf_q, irq_flag}, {8'h55, 1'b1});

        // R10: disabling the master aborts the transfer
        wr_ctrl(0, 1'b1, 4'b0010);
        wr_stat(1'b0, 1'b1);
        wr_ctrl(1, 1'b1, 4'b0010);
        pulse_read(); pulse_irq_clr();
        write_buf(8'h3A);
        tick(40);
        wr_ctrl(0, 1'b1, 4'b0010);
        tick(1);
        chk(sck_o == 1'b1, "R10 clock idle after disable", sck_o, 1);
        tick(600);
        chk(!irq_flag, "R10 no byte after disable", irq_flag, 0);

        // R10: reset mid-transfer
        wr_ctrl(1, 1'b1, 4'b0010);
        write_buf(8'hC6);
        tick(50);
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        chk(ctrl_q == 8'h00 && stat_q == 8'h00 && sck_o == 1'b0 && !irq_flag, "R10 reset mid-transfer",
            {ctrl_q, stat_q, sck_o, irq_flag}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule